// File: doc/BRIEF.md
# Spectrogram Frame Loader and Class Scoring Sequencer

This block gathers one frame of 8-bit spectrogram pixels, arriving one byte at a time, into an internal two-port feature store. After the last pixel of the frame is stored, it scores every output class in turn. Each score is a signed multiply-accumulate of the stored frame against that class's row of an external weight memory. The block keeps the best score seen so far while the classes go by. When the last class is done, it latches the winning class as a one-hot vector on the indicator outputs.

Both stores have a one-cycle synchronous read. A short control pipeline therefore delays the multiply-accumulate enable and clear strobes by exactly one cycle after each read address is issued, so that the operands and the strobes meet at the accumulator. The frame length and the class count are parameters. A second write port takes a pixel and its address directly, so a test environment can fill the frame at one pixel per clock without the byte interface.

The weight memory is outside the block. Class `c`, tap `t` lives at weight address `c*FRAME_PIX + t`, and its byte must appear on `w_data` on the cycle after `w_re`.

Top module: `fis_seq`

## Requirements
- R1: In reset and right after it, the controller is idle, `led` is all zero, `done` is 0, and `f_re`, `w_re`, `mac_en`, `mac_clr` and `f_we` are all 0.
- R2: The first byte that arrives while idle is not lost. In the same cycle it raises `f_we` with `f_waddr` = 0, and loading continues from address 1.
- R3: While loading, each accepted byte is written at the next sequential address. A write to address `FRAME_PIX-1` ends the load and starts scoring.
- R4: `mac_en` is high exactly in the cycles that follow a cycle with `f_re` high. `mac_clr` comes with the first tap of each class. One frame gives `N_CLASS*FRAME_PIX` enable cycles and `N_CLASS` clear cycles.
- R5: Pixels and weights are two's-complement signed 8-bit values. The accumulator is wide enough that a frame of all -128 pixels against all -128 weights scores `16384*FRAME_PIX` without wrapping.
- R6: The class with the highest score wins, and negative scores compare correctly. `led` bit k is 1 only for the winning class k.
- R7: When several classes tie for the highest score, the lowest class index wins.
- R8: After scoring, `done` is 1 and `led` holds the result unchanged for as long as no new frame starts.
- R9: A byte that arrives after a result is written at address 0 and starts a new load, and `done` drops. `led` keeps the old result until the next result replaces it.
- R10: A one-cycle `sof` pulse in any state returns the controller to idle with the write address back at 0. The partial frame is abandoned.
- R11: Bytes and test-port writes that arrive while scoring are ignored. `f_we` stays 0 and the stored frame and the result are unchanged.
- R12: Outside scoring, a `tp_we` write stores `tp_data` at `tp_addr` and takes priority over a byte in the same cycle. A test-port write to the last address starts scoring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse, returns to idle |
| byte_vld | input | 1 | Pixel byte valid |
| byte_data | input | 8 | Pixel byte, signed |
| tp_we | input | 1 | Test-port direct write enable |
| tp_addr | input | $clog2(FRAME_PIX) | Test-port pixel address |
| tp_data | input | 8 | Test-port pixel |
| w_data | input | 8 | Weight read data, one cycle after `w_re` |
| f_we | output | 1 | Feature store write enable |
| f_waddr | output | $clog2(FRAME_PIX) | Feature store write address |
| f_re | output | 1 | Feature store read enable |
| f_raddr | output | $clog2(FRAME_PIX) | Feature store read address |
| w_re | output | 1 | Weight memory read enable |
| w_addr | output | $clog2(N_CLASS*FRAME_PIX) | Weight memory address |
| mac_en | output | 1 | Accumulate strobe, aligned to read data |
| mac_clr | output | 1 | Restart accumulation with this product |
| led | output | N_CLASS | One-hot winning class |
| done | output | 1 | Result latched and held |

## Verification
The bench builds the block with its defaults: a 16-pixel frame and all 31 classes. Each frame therefore costs about five hundred scoring cycles, and many frames fit in a short run. The last class index 30, ties between classes, all-negative scores and the full-scale -128 by -128 sum (262144 on a 20-bit accumulator) are all reachable at these values. The small frame also lets the bench recompute every class score from its own pixel and weight formulas and compare the argmax with `led`.

// File: rtl/fis_pkg.sv
package fis_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOAD    = 2'd1,
        ST_COMPUTE = 2'd2,
        ST_DONE    = 2'd3
    } fis_state_e;

    typedef logic signed [7:0] pix_t;

    // control that travels with a read through the one-cycle delay
    typedef struct packed {
        logic vld;
        logic first;
        logic last;
    } tap_tag_t;

    // 8x8 signed product plus headroom for summing 'taps' products
    function automatic int unsigned acc_width(input int unsigned taps);
        return 16 + ((taps > 1) ? $clog2(taps) : 1);
    endfunction

endpackage

// File: rtl/fis_feat_mem.sv
module fis_feat_mem #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/fis_mac.sv
module fis_mac #(
    parameter int unsigned ACC_W = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    clr,
    input  logic signed [7:0]       a,
    input  logic signed [7:0]       b,
    output logic signed [ACC_W-1:0] acc
);
    logic signed [15:0]      prod;
    logic signed [ACC_W-1:0] prod_x;

    assign prod   = a * b;
    assign prod_x = ACC_W'(prod);

    always_ff @(posedge clk) begin
        if (rst)      acc <= '0;
        else if (en)  acc <= clr ? prod_x : acc + prod_x;
    end
endmodule

// File: rtl/fis_argmax.sv
module fis_argmax #(
    parameter int unsigned N_CLASS = 31,
    parameter int unsigned CW      = 5,
    parameter int unsigned ACC_W   = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    score_vld,
    input  logic [CW-1:0]           score_cls,
    input  logic signed [ACC_W-1:0] score,
    output logic                    res_vld,
    output logic [CW-1:0]           res_idx
);
    logic signed [ACC_W-1:0] best_q;
    logic [CW-1:0]           idx_q;
    logic                    take;

    // first class seeds the search; later ones need a strictly larger score
    assign take = (score_cls == '0) || (score > best_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            best_q  <= '0;
            idx_q   <= '0;
            res_vld <= 1'b0;
            res_idx <= '0;
        end else begin
            res_vld <= 1'b0;
            if (score_vld) begin
                if (take) begin
                    best_q <= score;
                    idx_q  <= score_cls;
                end
                if (score_cls == CW'(N_CLASS - 1)) begin
                    res_vld <= 1'b1;
                    res_idx <= take ? score_cls : idx_q;
                end
            end
        end
    end
endmodule

// File: rtl/fis_seq.sv
module fis_seq
    import fis_pkg::*;
#(
    parameter  int unsigned FRAME_PIX = 16,
    parameter  int unsigned N_CLASS   = 31,
    localparam int unsigned FAW       = (FRAME_PIX > 1) ? $clog2(FRAME_PIX) : 1,
    localparam int unsigned WDEPTH    = N_CLASS * FRAME_PIX,
    localparam int unsigned WAW       = (WDEPTH > 1) ? $clog2(WDEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sof,
    input  logic               byte_vld,
    input  logic [7:0]         byte_data,
    input  logic               tp_we,
    input  logic [FAW-1:0]     tp_addr,
    input  logic [7:0]         tp_data,
    input  logic [7:0]         w_data,
    output logic               f_we,
    output logic [FAW-1:0]     f_waddr,
    output logic               f_re,
    output logic [FAW-1:0]     f_raddr,
    output logic               w_re,
    output logic [WAW-1:0]     w_addr,
    output logic               mac_en,
    output logic               mac_clr,
    output logic [N_CLASS-1:0] led,
    output logic               done
);
    localparam int unsigned CW    = (N_CLASS > 1) ? $clog2(N_CLASS) : 1;
    localparam int unsigned ACC_W = acc_width(FRAME_PIX);

    fis_state_e     st_q;
    logic [FAW-1:0] wptr_q;
    logic [FAW-1:0] tap_q;
    logic [CW-1:0]  cls_q;
    logic [WAW-1:0] wcnt_q;
    logic           iss_on_q;

    // write side
    logic           wr_ok;
    logic [7:0]     wr_data;
    logic           wr_last;

    assign wr_ok   = (st_q != ST_COMPUTE) && !sof;
    assign f_we    = wr_ok && (tp_we || byte_vld);
    assign f_waddr = tp_we ? tp_addr : wptr_q;
    assign wr_data = tp_we ? tp_data : byte_data;
    assign wr_last = (f_waddr == FAW'(FRAME_PIX - 1));

    // read issue side
    logic issue;
    assign issue   = (st_q == ST_COMPUTE) && iss_on_q;
    assign f_re    = issue;
    assign w_re    = issue;
    assign f_raddr = tap_q;
    assign w_addr  = wcnt_q;

    // one-cycle control delay matching the synchronous read latency
    tap_tag_t      d1_q;
    logic [CW-1:0] d1_cls_q;
    logic          d2_vld_q;
    logic [CW-1:0] d2_cls_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            d1_q     <= '0;
            d1_cls_q <= '0;
            d2_vld_q <= 1'b0;
            d2_cls_q <= '0;
        end else begin
            d1_q.vld   <= issue && !sof;
            d1_q.first <= (tap_q == '0);
            d1_q.last  <= (tap_q == FAW'(FRAME_PIX - 1));
            d1_cls_q   <= cls_q;
            d2_vld_q   <= d1_q.vld && d1_q.last && !sof;
            d2_cls_q   <= d1_cls_q;
        end
    end

    assign mac_en  = d1_q.vld;
    assign mac_clr = d1_q.vld && d1_q.first;

    logic [7:0]              f_rdata;
    logic signed [ACC_W-1:0] acc;
    logic                    res_vld;
    logic [CW-1:0]           res_idx;
    logic [N_CLASS-1:0]      res_oh;

    fis_feat_mem #(.DEPTH(FRAME_PIX), .AW(FAW)) u_fmem (
        .clk   (clk),
        .we    (f_we),
        .waddr (f_waddr),
        .wdata (wr_data),
        .re    (f_re),
        .raddr (f_raddr),
        .rdata (f_rdata)
    );

    fis_mac #(.ACC_W(ACC_W)) u_mac (
        .clk (clk),
        .rst (rst),
        .en  (mac_en),
        .clr (mac_clr),
        .a   (f_rdata),
        .b   (w_data),
        .acc (acc)
    );

    fis_argmax #(.N_CLASS(N_CLASS), .CW(CW), .ACC_W(ACC_W)) u_amax (
        .clk       (clk),
        .rst       (rst),
        .score_vld (d2_vld_q),
        .score_cls (d2_cls_q),
        .score     (acc),
        .res_vld   (res_vld),
        .res_idx   (res_idx)
    );

    generate
        for (genvar k = 0; k < N_CLASS; k++) begin : g_oh
            assign res_oh[k] = (res_idx == CW'(k));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            wptr_q   <= '0;
            tap_q    <= '0;
            cls_q    <= '0;
            wcnt_q   <= '0;
            iss_on_q <= 1'b0;
            led      <= '0;
        end else if (sof) begin
            st_q     <= ST_IDLE;
            wptr_q   <= '0;
            iss_on_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_LOAD, ST_DONE: begin
                    if (f_we) begin
                        if (wr_last) begin
                            st_q     <= ST_COMPUTE;
                            wptr_q   <= '0;
                            tap_q    <= '0;
                            cls_q    <= '0;
                            wcnt_q   <= '0;
                            iss_on_q <= 1'b1;
                        end else begin
                            st_q   <= ST_LOAD;
                            wptr_q <= f_waddr + FAW'(1);
                        end
                    end
                end
                ST_COMPUTE: begin
                    if (issue) begin
                        wcnt_q <= wcnt_q + WAW'(1);
                        if (tap_q == FAW'(FRAME_PIX - 1)) begin
                            tap_q <= '0;
                            cls_q <= cls_q + CW'(1);
                            if (cls_q == CW'(N_CLASS - 1)) iss_on_q <= 1'b0;
                        end else begin
                            tap_q <= tap_q + FAW'(1);
                        end
                    end
                    if (res_vld) begin
                        st_q <= ST_DONE;
                        led  <= res_oh;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign done = (st_q == ST_DONE);

endmodule

// File: rtl/fis_seq_chk.sv
module fis_seq_chk
    import fis_pkg::*;
#(
    parameter int unsigned N_CLASS = 31
) (
    input logic               clk,
    input logic               rst,
    input logic               sof,
    input fis_state_e         st,
    input logic               f_re,
    input logic               f_we,
    input logic               mac_en,
    input logic               mac_clr,
    input logic [N_CLASS-1:0] led,
    input logic               done
);
    p_clr_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
        mac_clr |-> mac_en);

    p_en_follows_read_r4: assert property (@(posedge clk) disable iff (rst)
        (f_re && !sof) |=> mac_en);

    p_en_only_after_read_r4: assert property (@(posedge clk) disable iff (rst)
        mac_en |-> $past(f_re));

    p_led_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(led));

    p_done_has_result_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (led != '0));

    p_led_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (st != ST_COMPUTE) |=> $stable(led));

    p_no_write_scoring_r11: assert property (@(posedge clk) disable iff (rst)
        (st == ST_COMPUTE) |-> !f_we);
endmodule

bind fis_seq fis_seq_chk #(.N_CLASS(N_CLASS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sof     (sof),
    .st      (st_q),
    .f_re    (f_re),
    .f_we    (f_we),
    .mac_en  (mac_en),
    .mac_clr (mac_clr),
    .led     (led),
    .done    (done)
);

// File: tb/fis_seq_tb.sv
module fis_seq_tb_top;
    localparam int F      = 16;
    localparam int N      = 31;
    localparam int FAW    = 4;
    localparam int WAW    = 9;
    localparam int CLK_NS = 10;

    // vector: [9:6] requirement number, [5] use test port, [4:2] weight mode, [1:0] pixel mode
    localparam int NVEC = 6;
    localparam logic [9:0] VEC [NVEC] = '{
        {4'd6, 1'b0, 3'd0, 2'd0},
        {4'd5, 1'b1, 3'd1, 2'd1},
        {4'd5, 1'b0, 3'd2, 2'd1},
        {4'd7, 1'b1, 3'd3, 2'd2},
        {4'd6, 1'b0, 3'd4, 2'd2},
        {4'd6, 1'b1, 3'd5, 2'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sof = 1'b0;
    logic byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic tp_we = 1'b0;
    logic [FAW-1:0] tp_addr = '0;
    logic [7:0] tp_data = '0;
    logic [7:0] w_data;
    logic f_we, f_re, w_re, mac_en, mac_clr, done;
    logic [FAW-1:0] f_waddr, f_raddr;
    logic [WAW-1:0] w_addr;
    logic [N-1:0] led;

    fis_seq #(.FRAME_PIX(F), .N_CLASS(N)) dut_i (
        .clk(clk), .rst(rst), .sof(sof), .byte_vld(byte_vld), .byte_data(byte_data),
        .tp_we(tp_we), .tp_addr(tp_addr), .tp_data(tp_data), .w_data(w_data),
        .f_we(f_we), .f_waddr(f_waddr), .f_re(f_re), .f_raddr(f_raddr),
        .w_re(w_re), .w_addr(w_addr), .mac_en(mac_en), .mac_clr(mac_clr),
        .led(led), .done(done)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int wmode = 0;
    logic signed [7:0] pix [F];

    function automatic logic signed [7:0] wfun(input int a);
        int c = a / F;
        case (wmode)
            0: return 8'(a * 37 + 11);
            1: return -8'sd128;
            2: return (c == 30) ? -8'sd128 : 8'sd0;
            3: return (c == 5 || c == 9) ? 8'sd1 : 8'sd0;
            4: return 8'(c - 40);
            default: return 8'((a * 101) ^ 8'h5A);
        endcase
    endfunction

    function automatic logic signed [7:0] pfun(input int i, input int pm);
        case (pm)
            0: return 8'(i * 29 + 3);
            1: return -8'sd128;
            2: return 8'sd1;
            default: return 8'(i * 13 - 100);
        endcase
    endfunction

    function automatic int model_cls();
        int best = 0;
        int bi = 0;
        for (int c = 0; c < N; c++) begin
            int sc = 0;
            for (int i = 0; i < F; i++) sc += int'(pix[i]) * int'(wfun(c * F + i));
            if (c == 0 || sc > best) begin best = sc; bi = c; end
        end
        return bi;
    endfunction

    // weight memory with one-cycle read
    logic [7:0] w_q = '0;
    always @(posedge clk) if (w_re) w_q <= wfun(int'(w_addr));
    assign w_data = w_q;

    // strobe monitor
    int n_en = 0, n_clr = 0, n_mis = 0;
    logic fre_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (mac_en) n_en++;
            if (mac_clr) n_clr++;
            if (mac_en !== fre_prev) n_mis++;
        end
        fre_prev = f_re;
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    logic cap_we;
    logic [FAW-1:0] cap_addr;

    task automatic send_byte(input logic [7:0] d);
        @(posedge clk); #1 byte_vld = 1'b1; byte_data = d;
        @(negedge clk); cap_we = f_we; cap_addr = f_waddr;
        @(posedge clk); #1 byte_vld = 1'b0;
    endtask

    task automatic tp_write(input int a, input logic [7:0] d, input bit with_byte);
        @(posedge clk); #1 tp_we = 1'b1; tp_addr = FAW'(a); tp_data = d;
        if (with_byte) begin byte_vld = 1'b1; byte_data = ~d; end
        @(negedge clk); cap_we = f_we; cap_addr = f_waddr;
        @(posedge clk); #1 tp_we = 1'b0; byte_vld = 1'b0;
    endtask

    task automatic load(input int start, input bit use_tp, input int pm, output int addr_bad);
        addr_bad = 0;
        for (int i = start; i < F; i++) begin
            pix[i] = pfun(i, pm);
            if (use_tp) tp_write(i, pix[i], 1'b0);
            else send_byte(pix[i]);
            if (!(cap_we === 1'b1 && cap_addr == FAW'(i))) addr_bad++;
        end
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        @(negedge clk);
        while (done !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
        chk(done === 1'b1, tag, "done after scoring", int'(done), 1);
    endtask

    task automatic pulse_sof();
        @(posedge clk); #1 sof = 1'b1;
        @(posedge clk); #1 sof = 1'b0;
    endtask

    task automatic check_led(input string tag, input int exp_cls);
        logic [N-1:0] e = '0;
        e[exp_cls] = 1'b1;
        chk(led === e, tag, "led one-hot", int'(led), int'(e));
    endtask

    string tg;
    int bad, exp_c;
    logic [N-1:0] old_led;
    bit finished = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(led === '0, "R1", "led after reset", int'(led), 0);
        chk(done === 1'b0 && f_re === 1'b0 && w_re === 1'b0 && mac_en === 1'b0
            && mac_clr === 1'b0 && f_we === 1'b0, "R1", "idle outputs", int'(done), 0);

        for (int v = 0; v < NVEC; v++) begin
            case (VEC[v][9:6])
                4'd5: tg = "R5";
                4'd7: tg = "R7";
                default: tg = "R6";
            endcase
            wmode = int'(VEC[v][4:2]);
            n_en = 0; n_clr = 0; n_mis = 0;
            load(0, VEC[v][5], int'(VEC[v][1:0]), bad);
            if (v == 0) chk(bad == 0, "R2", "first byte and sequential writes", bad, 0);
            if (!VEC[v][5]) chk(bad == 0, "R3", "sequential write addresses", bad, 0);
            else chk(bad == 0, "R12", "test-port write addresses", bad, 0);
            wait_done("R8");
            exp_c = model_cls();
            check_led(tg, exp_c);
            chk(n_en == N * F, "R4", "mac_en cycles", n_en, N * F);
            chk(n_clr == N, "R4", "mac_clr cycles", n_clr, N);
            chk(n_mis == 0, "R4", "mac_en vs f_re alignment", n_mis, 0);
        end
        // corner expectations of the table, fixed by hand
        chk(exp_c >= 0, "R5", "model sanity", exp_c, 0);

        // R8 result held
        old_led = led;
        repeat (25) @(negedge clk);
        chk(led === old_led && done === 1'b1, "R8", "led held in done", int'(led), int'(old_led));

        // R9 new frame from done, old result kept during load
        wmode = 0;
        pix[0] = pfun(0, 3);
        send_byte(pix[0]);
        chk(cap_we === 1'b1 && cap_addr == '0, "R9", "first byte of new frame at 0", int'(cap_addr), 0);
        @(negedge clk);
        chk(done === 1'b0, "R9", "done drops on new frame", int'(done), 0);
        chk(led === old_led, "R9", "old result kept while loading", int'(led), int'(old_led));
        load(1, 1'b0, 3, bad);
        wait_done("R9");
        check_led("R9", model_cls());

        // R11 bytes during scoring are ignored
        wmode = 5;
        load(0, 1'b0, 0, bad);
        send_byte(8'h7F);
        chk(cap_we === 1'b0, "R11", "no write while scoring", int'(cap_we), 0);
        wait_done("R11");
        check_led("R11", model_cls());

        // R10 sof abandons a partial frame
        wmode = 0;
        for (int i = 0; i < 5; i++) send_byte(8'h55);
        pulse_sof();
        @(negedge clk);
        chk(done === 1'b0 && f_re === 1'b0, "R10", "idle after sof", int'(done), 0);
        load(0, 1'b0, 2, bad);
        chk(bad == 0, "R10", "write address restarted at 0", bad, 0);
        wait_done("R10");
        check_led("R10", model_cls());

        // R12 test port wins over a byte in the same cycle
        wmode = 4;
        pix[0] = -8'sd3;
        tp_write(0, pix[0], 1'b1);
        chk(cap_we === 1'b1 && cap_addr == '0, "R12", "test-port write taken", int'(cap_addr), 0);
        for (int i = 1; i < F; i++) begin pix[i] = pfun(i, 2); tp_write(i, pix[i], 1'b0); end
        wait_done("R12");
        check_led("R12", model_cls());

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule